// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog that resets the system when software stops servicing it. A control register holds three fields: an arm bit, a disarm-unlock bit and a 3-bit period selector. Software reaches the register through a single-cycle write strobe with a data word, and reads it back combinationally. When the arm bit is set, a counter advances on each cycle where the tick input is high. If the count reaches the selected limit, the block emits a one-cycle reset pulse and starts the count again. A kick pulse restarts the count from zero.

An ordinary write cannot turn the watchdog off. Software must first write ones to the arm and unlock bits in the same word. It then has a short window in which a write with the arm bit at zero disarms the watchdog. After that window the unlock bit drops by itself, and any later write that clears the arm bit is ignored.

Register word layout: bits [2:0] hold the period selector, bit 3 is the arm bit, bit 4 is the unlock bit, and bits [7:5] read as zero and are ignored on write.

Top module: `wdg_guard`

## Requirements
- R1: After a synchronous reset the read word is 0x00 (disarmed, period 0, unlock clear) and `wdt_rst_o` is low.
- R2: A write with bit 3 set arms the watchdog, and the read word shows bit 3 set. Bits [2:0] of every write load the period selector.
- R3: A write with bit 3 clear leaves the arm bit set when no unlock window is open. A write with bit 4 set but bit 3 clear opens no window.
- R4: A write with both bit 3 and bit 4 set opens the unlock window. A write with bit 3 clear in any of the next 4 cycles disarms the watchdog. Such a write also closes the window.
- R5: The read word shows bit 4 set for exactly 4 cycles after the unlocking write. A write with bit 3 clear in the 5th cycle or later is ignored.
- R6: The unlocking write also arms the watchdog when it was disarmed.
- R7: With period selector n, the reset pulse follows 2^(n+4) tick cycles after arming or after the previous pulse. The pulse lasts exactly one cycle.
- R8: A kick pulse sets the count to zero. The next timeout then needs a full 2^(n+4) ticks, and kicks that come often enough prevent any pulse.
- R9: While disarmed, no reset pulse is produced.
- R10: The count advances only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable; one watchdog tick per high cycle |
| kick_i | input | 1 | Service pulse; restarts the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write word |
| rd_data_o | output | 8 | Register read word |
| wdt_rst_o | output | 1 | One-cycle timeout reset pulse |

## Verification
The hardest case to reach is the edge of the disarm window: a clearing write that lands on exactly the fourth or the fifth cycle after the unlocking write. The bench sweeps the gap between the two writes from zero to five idle cycles. It re-arms through an ordinary write before each trial, so every gap starts from the same state. At each boundary it checks both the arm bit and the unlock bit in the read word. The timeout sweep covers all eight period codes and measures two back-to-back intervals in each. A second sweep uses a sparse tick pattern, so that counting cycles instead of ticks would show up as a mismatch.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W  = 8;
    localparam int PER_W   = 3;
    localparam int ARM_BIT = PER_W;
    localparam int UNL_BIT = PER_W + 1;

    typedef struct packed {
        logic             unlock;
        logic             arm;
        logic [PER_W-1:0] per;
    } wdg_ctrl_t;

    localparam int CTRL_W = $bits(wdg_ctrl_t);

    function automatic wdg_ctrl_t unpack_word(input logic [DATA_W-1:0] w);
        wdg_ctrl_t c;
        c.per    = w[PER_W-1:0];
        c.arm    = w[ARM_BIT];
        c.unlock = w[UNL_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input wdg_ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_W-1:0] = c;
        return w;
    endfunction

endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
    import wdg_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output wdg_ctrl_t         ctrl_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);

    logic             arm_q;
    logic [PER_W-1:0] per_q;
    logic [WIN_W-1:0] win_q;
    logic             win_open;
    wdg_ctrl_t        req;

    assign win_open = (win_q != '0);
    assign req      = unpack_word(wr_data_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            per_q <= '0;
            win_q <= '0;
        end else begin
            if (wr_en_i) begin
                per_q <= req.per;
                if (req.arm)
                    arm_q <= 1'b1;
                else if (win_open)
                    arm_q <= 1'b0;

                if (req.arm && req.unlock)
                    win_q <= WIN_W'(WIN_CYC);
                else if (!req.arm && win_open)
                    win_q <= '0;
                else if (win_open)
                    win_q <= win_q - 1'b1;
            end else if (win_open) begin
                win_q <= win_q - 1'b1;
            end
        end
    end

    assign ctrl_o.unlock = win_open;
    assign ctrl_o.arm    = arm_q;
    assign ctrl_o.per    = per_q;
    assign rd_data_o     = pack_word(ctrl_o);

    // R3
    arm_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(arm_q) |-> $past(win_open && wr_en_i && !wr_data_i[ARM_BIT]));

    // R4
    win_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(win_open) |-> $past(wr_en_i && wr_data_i[ARM_BIT] && wr_data_i[UNL_BIT]));

    // R6
    unlock_arms_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(win_open) |-> arm_q);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int BASE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             arm_i,
    input  logic [PER_W-1:0] per_i,
    output logic             wdt_rst_o
);
    localparam int CNT_W = BASE_SHIFT + (1 << PER_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic [31:0]      lim_wide;
    logic             pulse_q;

    assign lim_wide = (32'd1 << (32'(per_i) + BASE_SHIFT)) - 32'd1;
    assign lim      = lim_wide[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!arm_i || kick_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == lim) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign wdt_rst_o = pulse_q;

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |=> !wdt_rst_o);

    // R9
    armed_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |-> $past(arm_i && tick_i && !kick_i));

    // R10
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $past(arm_i && !tick_i && !kick_i) |-> cnt_q == $past(cnt_q));

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int BASE_SHIFT = 4,
    parameter int WIN_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              kick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wdt_rst_o
);
    wdg_ctrl_t ctrl;

    wdg_ctrl #(.WIN_CYC(WIN_CYC)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl),
        .rd_data_o (rd_data_o)
    );

    wdg_counter #(.BASE_SHIFT(BASE_SHIFT)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .kick_i    (kick_i),
        .arm_i     (ctrl.arm),
        .per_i     (ctrl.per),
        .wdt_rst_o (wdt_rst_o)
    );

endmodule

// File: tb/wdg_guard_tb_top.sv
module wdg_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       kick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       wdt_rst_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wdg_guard dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .kick_i(kick_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .wdt_rst_o(wdt_rst_o)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] enc(input bit u, input bit a, input int p);
        return {3'b000, u, a, 3'(p)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit u, input bit a, input int p);
        tick_i    = 1'b0;
        wr_data_i = enc(u, a, p);
        wr_en_i   = 1'b1;
        @(posedge clk); #1;
        wr_en_i   = 1'b0;
    endtask

    task automatic idle(input int n);
        tick_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // counts tick edges until a pulse is seen; div sets the tick spacing
    task automatic measure(input int div, output int ticks, output bit seen);
        ticks = 0;
        seen  = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            tick_i = ((i % div) == 0);
            @(posedge clk);
            if (tick_i) ticks++;
            #1;
            if (wdt_rst_o) begin
                seen = 1'b1;
                break;
            end
        end
        tick_i = 1'b0;
    endtask

    task automatic disarm(input int p);
        wr(1'b1, 1'b1, p);
        wr(1'b0, 1'b0, p);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired at cycle %0d expected finish before %0d", cycles, 150000);
                finish_run();
            end
        end
    end

    initial begin
        int t;
        bit s;
        int pulses;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(rd_data_o == 8'h00, "R1 read word", rd_data_o, 0);
        chk(wdt_rst_o == 1'b0, "R1 pulse low", wdt_rst_o, 0);

        // R2 arming write
        wr(1'b0, 1'b1, 5);
        chk(rd_data_o == enc(0, 1, 5), "R2 armed readback", rd_data_o, enc(0, 1, 5));

        // R3 ordinary clearing write ignored
        wr(1'b0, 1'b0, 5);
        chk(rd_data_o[3] == 1'b1, "R3 plain clear ignored", rd_data_o[3], 1);
        wr(1'b1, 1'b0, 5);
        chk(rd_data_o[4] == 1'b0, "R3 unlock without arm opens no window", rd_data_o[4], 0);
        wr(1'b0, 1'b0, 5);
        chk(rd_data_o[3] == 1'b1, "R3 clear after bad unlock ignored", rd_data_o[3], 1);

        // R4 R5 window edge sweep
        for (int k = 0; k <= 5; k++) begin
            wr(1'b0, 1'b1, 0);
            idle(6);
            wr(1'b1, 1'b1, 0);
            chk(rd_data_o[4] == 1'b1, "R5 unlock bit visible", rd_data_o[4], 1);
            for (int j = 0; j < k; j++) begin
                idle(1);
                chk(rd_data_o[4] == (j < 3), "R5 unlock bit lifetime", rd_data_o[4], (j < 3));
            end
            wr(1'b0, 1'b0, 0);
            chk(rd_data_o[3] == (k > 3), "R4 R5 clear after gap", rd_data_o[3], (k > 3));
            chk(rd_data_o[4] == 1'b0, "R4 window closed after clear", rd_data_o[4], 0);
        end
        idle(6);
        disarm(0);
        chk(rd_data_o[3] == 1'b0, "R4 disarmed", rd_data_o[3], 0);

        // R6 unlocking write arms from disarmed state
        wr(1'b1, 1'b1, 2);
        chk(rd_data_o[3] == 1'b1, "R6 unlock write arms", rd_data_o[3], 1);
        idle(6);

        // R7 sweep all periods, two intervals each
        for (int p = 0; p < 8; p++) begin
            disarm(p);
            wr(1'b0, 1'b1, p);
            measure(1, t, s);
            chk(s && t == (1 << (p + 4)), "R7 first interval", t, 1 << (p + 4));
            tick_i = 1'b0;
            @(posedge clk); #1;
            chk(wdt_rst_o == 1'b0, "R7 pulse one cycle", wdt_rst_o, 0);
            measure(1, t, s);
            chk(s && t == (1 << (p + 4)), "R7 second interval", t, 1 << (p + 4));
        end

        // R10 sparse ticks
        for (int d = 2; d <= 4; d++) begin
            disarm(1);
            wr(1'b0, 1'b1, 1);
            measure(d, t, s);
            chk(s && t == 32, "R10 sparse tick count", t, 32);
        end

        // R8 kick restart
        disarm(0);
        wr(1'b0, 1'b1, 0);
        tick_i = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
        end
        kick_i = 1'b1;
        @(posedge clk); #1;
        kick_i = 1'b0;
        chk(wdt_rst_o == 1'b0, "R8 no pulse before kick", wdt_rst_o, 0);
        measure(1, t, s);
        chk(s && t == 16, "R8 interval after kick", t, 16);
        pulses = 0;
        tick_i = 1'b1;
        for (int i = 0; i < 80; i++) begin
            kick_i = ((i % 8) == 7);
            @(posedge clk); #1;
            if (wdt_rst_o) pulses++;
        end
        kick_i = 1'b0;
        chk(pulses == 0, "R8 regular kicks suppress pulse", pulses, 0);

        // R9 disarmed never pulses
        disarm(0);
        pulses = 0;
        tick_i = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if (wdt_rst_o) pulses++;
        end
        tick_i = 1'b0;
        chk(pulses == 0, "R9 no pulse while disarmed", pulses, 0);
        chk(rd_data_o == enc(0, 0, 0), "R9 disarmed readback", rd_data_o, enc(0, 0, 0));

        finish_run();
    end

endmodule